// File: doc/BRIEF.md
# I2C Slave Receiver Status Engine

This block is the receive side of a byte-oriented I2C slave. It watches synchronised SCL and SDA for START and STOP, shifts in the address byte and the data bytes that follow, and pulls SDA low in the ninth clock to acknowledge. A byte is acknowledged when it carries the block's own 7-bit address with the write bit, or the general call address, and the acknowledge-enable input allows it. Each data byte is acknowledged or refused by the same input.

After every bus event the block loads a byte-wide status code, raises its interrupt flag and holds SCL low. The bus stays stalled until software pulses the clear input. Software uses the stall to read the data byte and to choose the acknowledge for the next byte. After a refused byte, a STOP or a repeated START, the block drops to the not-addressed state. If a start request is present when the flag is cleared there, the block asks the master side for a START once the bus is free.

Top module: `i2c_srx_engine`

## Requirements
- R1: A write-direction address byte whose bits 7:1 equal own_adr_i[7:1] is acknowledged when ack_en_i is 1. SDA is pulled low through the ninth SCL high phase. The status becomes 0x60 and irq_o rises.
- R2: If arb_lost_i pulsed since the last completed address phase, the address status is 0x68 for own address and 0x78 for general call. A pulse in the same cycle as address completion also counts.
- R3: The byte 0x00 is acknowledged with status 0x70 only when own_adr_i[0] is 1 and ack_en_i is 1. Otherwise it is refused and no status is raised.
- R4: A data byte in the addressed state appears on rx_data_o. Its status is 0x80 if acknowledged or 0x88 if refused after own address. After a general call the codes are 0x90 and 0x98.
- R5: Whether a data byte is acknowledged follows ack_en_i as sampled when SCL falls after the eighth data bit.
- R6: After a refused byte the block acknowledges nothing until the next START. With ack_en_i at 0 it acknowledges neither its own address nor the general call.
- R7: While irq_o is 1, scl_low_o holds SCL low and the flag stays set. A one-cycle irq_clr_i clears irq_o, sets status to 0xF8 and releases SCL. After reset irq_o is 0 and status is 0xF8.
- R8: A STOP or repeated START while addressed raises status 0xA0 and leaves the addressed state. A repeated START begins a new address phase.
- R9: If sta_req_i is 1 when irq_o is cleared in the not-addressed state, start_go_o pulses for exactly one cycle. The pulse comes once the bus is free (no START since the last STOP), and never while the bus is busy.
- R10: START is SDA falling and STOP is SDA rising while SCL is high, both seen on two-stage synchronised inputs. A read-direction or non-matching address gets no acknowledge and no status.
- R11: When a bus event and irq_clr_i fall in the same cycle, the event wins: irq_o stays 1 with the new status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_low_o | output | 1 | Pull SCL low (clock stretch) |
| sda_low_o | output | 1 | Pull SDA low (acknowledge) |
| own_adr_i | input | 8 | Bits 7:1 slave address, bit 0 general call enable |
| ack_en_i | input | 1 | Assert-acknowledge control |
| sta_req_i | input | 1 | Start request control |
| irq_clr_i | input | 1 | Pulse to clear the interrupt flag |
| arb_lost_i | input | 1 | Pulse: master side lost arbitration |
| irq_o | output | 1 | Interrupt flag |
| stat_o | output | 8 | Status code |
| rx_data_o | output | 8 | Last received data byte |
| start_go_o | output | 1 | One-cycle request to issue a START |

## Verification
Two pairs of functions can coincide in one cycle. One pair is the arbitration-lost pulse and the completion of the address byte. The other is a software clear and the event that raises the flag. The bench places arb_lost_i, and separately irq_clr_i, in the exact cycle the ninth SCL fall is acted on. It counts the synchroniser stages and the edge register from the moment it drives SCL low. It then expects 0x78 with the flag still set, and the flag held with status 0x80 despite the clear.

// File: rtl/i2c_srx_pkg.sv
package i2c_srx_pkg;
  typedef enum logic [1:0] {BUS_NADDR, BUS_ADDR, BUS_DATA} srx_state_e;

  localparam logic [7:0] SC_OWN_W         = 8'h60;
  localparam logic [7:0] SC_OWN_W_AL      = 8'h68;
  localparam logic [7:0] SC_GC            = 8'h70;
  localparam logic [7:0] SC_GC_AL         = 8'h78;
  localparam logic [7:0] SC_OWN_DATA_ACK  = 8'h80;
  localparam logic [7:0] SC_OWN_DATA_NACK = 8'h88;
  localparam logic [7:0] SC_GC_DATA_ACK   = 8'h90;
  localparam logic [7:0] SC_GC_DATA_NACK  = 8'h98;
  localparam logic [7:0] SC_STOP_RS       = 8'hA0;
  localparam logic [7:0] SC_IDLE          = 8'hF8;
endpackage

// File: rtl/i2c_srx_sync.sv
module i2c_srx_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg[i] <= '1;  // idle bus is high
      else if (i == 0) stg[i] <= d_i;
      else stg[i] <= stg[(i == 0) ? 0 : i-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/i2c_srx_cond_det.sv
module i2c_srx_cond_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_s_i,
  input  logic sda_s_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s_i;
      sda_q <= sda_s_i;
    end
  end

  assign scl_rise_o = scl_s_i & ~scl_q;
  assign scl_fall_o = ~scl_s_i & scl_q;
  assign start_o    = scl_s_i & scl_q & sda_q & ~sda_s_i;
  assign stop_o     = scl_s_i & scl_q & ~sda_q & sda_s_i;
endmodule

// File: rtl/i2c_srx_byte_rx.sv
module i2c_srx_byte_rx #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              restart_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              sda_s_i,
  output logic [DATA_W-1:0] byte_o,
  output logic              ack_slot_o,
  output logic              done_o
);
  localparam int CNT_W = $clog2(DATA_W + 2);
  localparam logic [CNT_W-1:0] CNT_DATA = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] CNT_ACK  = CNT_W'(DATA_W + 1);

  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] sr_q;
  logic              run;

  assign run = en_i & ~restart_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sr_q  <= '0;
    end else if (!run) begin
      cnt_q <= '0;
    end else if (scl_rise_i && cnt_q < CNT_DATA) begin
      sr_q  <= {sr_q[DATA_W-2:0], sda_s_i};
      cnt_q <= cnt_q + 1'b1;
    end else if (scl_rise_i && cnt_q == CNT_DATA) begin
      cnt_q <= CNT_ACK;
    end else if (scl_fall_i && cnt_q == CNT_ACK) begin
      cnt_q <= '0;
    end
  end

  assign byte_o     = sr_q;
  assign ack_slot_o = run & scl_fall_i & (cnt_q == CNT_DATA);
  assign done_o     = run & scl_fall_i & (cnt_q == CNT_ACK);
endmodule

// File: rtl/i2c_srx_ctrl.sv
module i2c_srx_ctrl
  import i2c_srx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              ack_slot_i,
  input  logic              done_i,
  input  logic [DATA_W-1:0] byte_i,
  input  logic [DATA_W-1:0] own_adr_i,
  input  logic              ack_en_i,
  input  logic              sta_req_i,
  input  logic              irq_clr_i,
  input  logic              arb_lost_i,
  output srx_state_e        state_o,
  output logic              irq_o,
  output logic [7:0]        stat_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              sda_low_o,
  output logic              start_go_o
);
  srx_state_e        state_q;
  logic              irq_q, sda_low_q, gc_q, alost_q, busy_q, pend_q, go_q;
  logic [7:0]        stat_q;
  logic [DATA_W-1:0] rx_q;
  logic              gc_hit, own_hit, alost_now;
  logic [7:0]        addr_code, data_code;

  assign gc_hit    = (byte_i == '0) & own_adr_i[0];
  assign own_hit   = (byte_i != '0) & ~byte_i[0] &
                     (byte_i[DATA_W-1:1] == own_adr_i[DATA_W-1:1]);
  assign alost_now = alost_q | arb_lost_i;
  assign addr_code = gc_q ? (alost_now ? SC_GC_AL : SC_GC)
                          : (alost_now ? SC_OWN_W_AL : SC_OWN_W);
  assign data_code = gc_q ? (sda_low_q ? SC_GC_DATA_ACK : SC_GC_DATA_NACK)
                          : (sda_low_q ? SC_OWN_DATA_ACK : SC_OWN_DATA_NACK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= BUS_NADDR;
      irq_q     <= 1'b0;
      stat_q    <= SC_IDLE;
      rx_q      <= '0;
      sda_low_q <= 1'b0;
      gc_q      <= 1'b0;
      alost_q   <= 1'b0;
      busy_q    <= 1'b0;
      pend_q    <= 1'b0;
      go_q      <= 1'b0;
    end else begin
      go_q <= 1'b0;
      if (arb_lost_i) alost_q <= 1'b1;

      if (irq_clr_i && irq_q) begin
        irq_q  <= 1'b0;
        stat_q <= SC_IDLE;
        if (state_q == BUS_NADDR && sta_req_i) pend_q <= 1'b1;
      end

      if (pend_q && !busy_q && !irq_q) begin
        go_q   <= 1'b1;
        pend_q <= 1'b0;
      end

      // bus events are assigned last so they win over a same-cycle clear
      if (start_i) begin
        busy_q    <= 1'b1;
        sda_low_q <= 1'b0;
        if (state_q == BUS_DATA) begin
          stat_q <= SC_STOP_RS;
          irq_q  <= 1'b1;
        end
        state_q <= BUS_ADDR;
      end else if (stop_i) begin
        busy_q    <= 1'b0;
        sda_low_q <= 1'b0;
        if (state_q == BUS_DATA) begin
          stat_q <= SC_STOP_RS;
          irq_q  <= 1'b1;
        end
        state_q <= BUS_NADDR;
      end else if (ack_slot_i) begin
        if (state_q == BUS_ADDR) begin
          if (ack_en_i && (own_hit || gc_hit)) begin
            sda_low_q <= 1'b1;
            gc_q      <= gc_hit;
          end else begin
            state_q <= BUS_NADDR;
          end
        end else if (state_q == BUS_DATA) begin
          sda_low_q <= ack_en_i;
        end
      end else if (done_i) begin
        sda_low_q <= 1'b0;
        irq_q     <= 1'b1;
        if (state_q == BUS_ADDR) begin
          stat_q  <= addr_code;
          alost_q <= 1'b0;
          state_q <= BUS_DATA;
        end else begin
          stat_q <= data_code;
          rx_q   <= byte_i;
          if (!sda_low_q) state_q <= BUS_NADDR;
        end
      end
    end
  end

  assign state_o    = state_q;
  assign irq_o      = irq_q;
  assign stat_o     = stat_q;
  assign rx_data_o  = rx_q;
  assign sda_low_o  = sda_low_q;
  assign start_go_o = go_q;
endmodule

// File: rtl/i2c_srx_engine.sv
module i2c_srx_engine
  import i2c_srx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       scl_low_o,
  output logic       sda_low_o,
  input  logic [7:0] own_adr_i,
  input  logic       ack_en_i,
  input  logic       sta_req_i,
  input  logic       irq_clr_i,
  input  logic       arb_lost_i,
  output logic       irq_o,
  output logic [7:0] stat_o,
  output logic [7:0] rx_data_o,
  output logic       start_go_o
);
  localparam int DATA_W = 8;

  logic [1:0]        bus_s;
  logic              scl_rise, scl_fall, start, stop, ack_slot, done;
  logic [DATA_W-1:0] byte_rx;
  srx_state_e        state;

  i2c_srx_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .d_i({scl_i, sda_i}), .q_o(bus_s)
  );

  i2c_srx_cond_det u_cond (
    .clk_i, .rst_ni, .scl_s_i(bus_s[1]), .sda_s_i(bus_s[0]),
    .scl_rise_o(scl_rise), .scl_fall_o(scl_fall), .start_o(start), .stop_o(stop)
  );

  i2c_srx_byte_rx #(.DATA_W(DATA_W)) u_byte (
    .clk_i, .rst_ni, .en_i(state != BUS_NADDR), .restart_i(start),
    .scl_rise_i(scl_rise), .scl_fall_i(scl_fall), .sda_s_i(bus_s[0]),
    .byte_o(byte_rx), .ack_slot_o(ack_slot), .done_o(done)
  );

  i2c_srx_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk_i, .rst_ni, .start_i(start), .stop_i(stop), .ack_slot_i(ack_slot),
    .done_i(done), .byte_i(byte_rx), .own_adr_i, .ack_en_i, .sta_req_i,
    .irq_clr_i, .arb_lost_i, .state_o(state), .irq_o, .stat_o, .rx_data_o,
    .sda_low_o, .start_go_o
  );

  assign scl_low_o = irq_o;
endmodule

// File: rtl/i2c_srx_chk.sv
module i2c_srx_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       scl_i,
  input logic       irq_o,
  input logic       irq_clr_i,
  input logic [7:0] stat_o,
  input logic       sda_low_o,
  input logic       start_go_o
);
  AST_IDLE_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_o |-> stat_o == 8'hF8); // R7
  AST_IRQ_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && !irq_clr_i |=> irq_o); // R7
  AST_NO_ACK_WHILE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> !sda_low_o); // R1
  AST_ACK_ON_LOW_SCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_low_o) |-> !scl_i); // R5
  AST_GO_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_go_o |=> !start_go_o); // R9
  AST_GO_NO_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_go_o |-> !irq_o); // R9
  AST_EVENT_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> stat_o inside {8'h60, 8'h68, 8'h70, 8'h78, 8'h80,
                                    8'h88, 8'h90, 8'h98, 8'hA0}); // R4
endmodule

bind i2c_srx_engine i2c_srx_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .scl_i(scl_i), .irq_o(irq_o),
  .irq_clr_i(irq_clr_i), .stat_o(stat_o), .sda_low_o(sda_low_o),
  .start_go_o(start_go_o)
);

// File: tb/i2c_srx_engine_tb_top.sv
`timescale 1ns/1ps
module i2c_srx_engine_tb_top;
  localparam int HALF = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [7:0] own_adr = 8'hB5;
  logic ack_en = 1'b1, sta_req = 1'b0, irq_clr = 1'b0, arb_lost = 1'b0;
  logic scl_low, sda_low, irq, start_go;
  logic [7:0] stat, rx_data;
  logic scl_bus, sda_bus;
  int checks = 0, fails = 0, go_cnt = 0;

  always #2 clk = ~clk;

  assign scl_bus = scl_m & ~scl_low;
  assign sda_bus = sda_m & ~sda_low;

  i2c_srx_engine dut_i (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_bus), .sda_i(sda_bus),
    .scl_low_o(scl_low), .sda_low_o(sda_low), .own_adr_i(own_adr),
    .ack_en_i(ack_en), .sta_req_i(sta_req), .irq_clr_i(irq_clr),
    .arb_lost_i(arb_lost), .irq_o(irq), .stat_o(stat), .rx_data_o(rx_data),
    .start_go_o(start_go)
  );

  always @(posedge clk) if (start_go) go_cnt++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    sda_m = 1'b1; waitn(HALF);
    scl_m = 1'b1; waitn(HALF);
    sda_m = 1'b0; waitn(HALF);
    scl_m = 1'b0; waitn(HALF);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; waitn(HALF);
    scl_m = 1'b1; waitn(HALF);
    sda_m = 1'b1; waitn(HALF);
  endtask

  task automatic send_bit(input logic b);
    sda_m = b;    waitn(HALF);
    scl_m = 1'b1; waitn(HALF);
    scl_m = 1'b0; waitn(2);
  endtask

  // coinc: 0 none, 1 arb_lost, 2 irq_clr in the cycle the ninth fall is acted on
  task automatic send_byte(input logic [7:0] b, input int coinc, output logic acked);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_m = 1'b1; waitn(HALF);
    scl_m = 1'b1; waitn(4);
    acked = ~sda_bus;
    waitn(HALF - 4);
    scl_m = 1'b0;
    waitn(2);
    if (coinc == 1) arb_lost = 1'b1;
    if (coinc == 2) irq_clr = 1'b1;
    waitn(1);
    arb_lost = 1'b0;
    irq_clr  = 1'b0;
    waitn(HALF);
  endtask

  task automatic clear_irq(input string req);
    irq_clr = 1'b1; waitn(1);
    irq_clr = 1'b0; waitn(1);
    chk(req, irq, 1'b0);
    chk(req, stat, 8'hF8);
    chk(req, scl_low, 1'b0);
  endtask

  task automatic t_reset;
    chk("R7 reset irq", irq, 1'b0);
    chk("R7 reset stat", stat, 8'hF8);
    chk("R7 reset scl", scl_low, 1'b0);
    chk("R1 reset sda", sda_low, 1'b0);
    chk("R9 reset go", start_go, 1'b0);
  endtask

  task automatic t_own_write;
    logic a;
    own_adr = 8'hB5; ack_en = 1'b1;
    bus_start;
    send_byte(8'hB4, 0, a);
    chk("R1 ack", a, 1'b1);
    chk("R1 stat", stat, 8'h60);
    chk("R7 irq", irq, 1'b1);
    chk("R7 scl held", scl_low, 1'b1);
    clear_irq("R7 clear");
    send_byte(8'h3C, 0, a);
    chk("R4 data ack", a, 1'b1);
    chk("R4 stat 80", stat, 8'h80);
    chk("R4 rx", rx_data, 8'h3C);
    ack_en = 1'b0;
    clear_irq("R7 clear2");
    send_byte(8'hC3, 0, a);
    chk("R5 nack", a, 1'b0);
    chk("R4 stat 88", stat, 8'h88);
    chk("R4 rx2", rx_data, 8'hC3);
    ack_en = 1'b1;
    clear_irq("R7 clear3");
    send_byte(8'hB4, 0, a);
    chk("R6 no ack after nack", a, 1'b0);
    chk("R6 no irq", irq, 1'b0);
    bus_stop;
    chk("R6 stop not addressed", irq, 1'b0);
  endtask

  task automatic t_read_dir;
    logic a;
    bus_start;
    send_byte(8'hB5, 0, a);
    chk("R10 read dir ack", a, 1'b0);
    chk("R10 read dir irq", irq, 1'b0);
    bus_stop;
    bus_start;
    send_byte(8'h42, 0, a);
    chk("R10 other addr ack", a, 1'b0);
    chk("R10 other addr irq", irq, 1'b0);
    bus_stop;
  endtask

  task automatic t_gc;
    logic a;
    own_adr = 8'hB5;
    bus_start;
    send_byte(8'h00, 0, a);
    chk("R3 gc ack", a, 1'b1);
    chk("R3 gc stat", stat, 8'h70);
    clear_irq("R7 gc clear");
    send_byte(8'h11, 0, a);
    chk("R4 gc data", stat, 8'h90);
    chk("R4 gc rx", rx_data, 8'h11);
    ack_en = 1'b0;
    clear_irq("R7 gc clear2");
    send_byte(8'h22, 0, a);
    chk("R4 gc nack", a, 1'b0);
    chk("R4 gc stat 98", stat, 8'h98);
    ack_en = 1'b1;
    clear_irq("R7 gc clear3");
    bus_stop;
    own_adr = 8'hB4;
    bus_start;
    send_byte(8'h00, 0, a);
    chk("R3 gc disabled ack", a, 1'b0);
    chk("R3 gc disabled irq", irq, 1'b0);
    bus_stop;
    own_adr = 8'hB5;
  endtask

  task automatic t_aa_off;
    logic a;
    ack_en = 1'b0;
    bus_start;
    send_byte(8'hB4, 0, a);
    chk("R6 aa0 own", a, 1'b0);
    bus_stop;
    bus_start;
    send_byte(8'h00, 0, a);
    chk("R6 aa0 gc", a, 1'b0);
    chk("R6 aa0 irq", irq, 1'b0);
    bus_stop;
    ack_en = 1'b1;
  endtask

  task automatic t_stop_rs;
    logic a;
    bus_start;
    send_byte(8'hB4, 0, a);
    clear_irq("R8 pre");
    bus_stop;
    chk("R8 stop stat", stat, 8'hA0);
    chk("R8 stop irq", irq, 1'b1);
    clear_irq("R8 stop clear");
    bus_start;
    send_byte(8'hB4, 0, a);
    clear_irq("R8 pre2");
    send_byte(8'h5A, 0, a);
    chk("R8 data before rs", stat, 8'h80);
    clear_irq("R8 pre3");
    bus_start;
    chk("R8 rs stat", stat, 8'hA0);
    clear_irq("R8 rs clear");
    send_byte(8'hB4, 0, a);
    chk("R8 new addr phase", stat, 8'h60);
    clear_irq("R8 post");
    bus_stop;
    clear_irq("R8 final");
  endtask

  task automatic t_arb_lost;
    logic a;
    arb_lost = 1'b1; waitn(1); arb_lost = 1'b0;
    bus_start;
    send_byte(8'hB4, 0, a);
    chk("R2 own after al", stat, 8'h68);
    clear_irq("R2 clear");
    bus_stop;
    clear_irq("R2 clear stop");
    bus_start;
    send_byte(8'h00, 1, a);
    chk("R2 R11 gc al same cycle", stat, 8'h78);
    clear_irq("R2 clear2");
    send_byte(8'h01, 0, a);
    chk("R2 al consumed", stat, 8'h90);
    clear_irq("R2 clear3");
    bus_stop;
    clear_irq("R2 clear4");
  endtask

  task automatic t_same_cycle_clear;
    logic a;
    bus_start;
    send_byte(8'hB4, 0, a);
    clear_irq("R11 pre");
    send_byte(8'h77, 2, a);
    chk("R11 event wins irq", irq, 1'b1);
    chk("R11 event wins stat", stat, 8'h80);
    clear_irq("R11 post");
    bus_stop;
    clear_irq("R11 stop");
  endtask

  task automatic t_start_req;
    logic a;
    bus_start;
    send_byte(8'hB4, 0, a);
    ack_en = 1'b0;
    clear_irq("R9 pre");
    send_byte(8'h10, 0, a);
    chk("R9 nack stat", stat, 8'h88);
    go_cnt  = 0;
    sta_req = 1'b1;
    clear_irq("R9 clear");
    sta_req = 1'b0;
    ack_en  = 1'b1;
    waitn(20);
    chk("R9 no go while busy", go_cnt, 0);
    bus_stop;
    waitn(4);
    chk("R9 one go after stop", go_cnt, 1);
  endtask

  initial begin
    waitn(5);
    rst_n = 1'b1;
    waitn(3);
    t_reset;
    t_own_write;
    t_read_dir;
    t_gc;
    t_aa_off;
    t_stop_rs;
    t_arb_lost;
    t_same_cycle_clear;
    t_start_req;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule